// File: doc/BRIEF.md
# Motor Controller Command Decoder

This block sits between a byte stream coming from a host link and the register file of a stepper motor controller. Each incoming byte is an opcode. The block decodes it in stages: first on bits 7:6, then on bits 5:3, then on bits 2:0. Depending on the opcode, the block changes the register file immediately, collects one or two operand bytes first, or queues one or two response bytes on an outbound byte stream. Both streams use a valid/ready handshake.

The register file holds the following:
- a 16-bit target position and a 16-bit current position
- slow, fast and ramp rates, and a ramp amount
- a complement mask and a drive-table selector
- a power-down flag
- interrupt enable and pending flags
- a saturating glitch counter
- a pointer into a short identification string

The drive-related registers are brought out as ports for the motor sequencer. The glitch counter and the ID pointer are visible only through commands.

Top module: `motor_cmd_decoder`

## Requirements
- R1: Opcodes 000x_xxxx increment the 16-bit target position by one, and opcodes 001x_xxxx decrement it by one. Both wrap modulo 2^16, with carry or borrow reaching the high byte.
- R2: Opcode 0100_0kkk writes the byte that follows it into register kkk. Opcode 0100_1kkk returns register kkk as one response byte. The index kkk selects, in order 0 to 7: target high, target low, current high, current low, slow rate, fast rate, ramp rate, ramp amount.
- R3: Opcode 0101_abcd sets comp_mask to 0b000a_0bcd. Opcode 0110_1100 returns 0b0000_abcd, rebuilt from comp_mask bit 4 and bits 2:0.
- R4: Opcode 0110_00ss sets wave_sel to ss, and opcode 0110_0111 returns wave_sel in bits 1:0. Opcode 0110_010p sets power_down to p, and opcode 0110_0110 returns power_down as 0x00 or 0x01.
- R5: Opcodes 0110_1000 and 0110_1001 take two operand bytes, high byte first. They load the target position and the current position respectively. Opcodes 0110_1010 and 0110_1011 return the target and the current position respectively, as two bytes, low byte first.
- R6: Opcode 0110_1111 sets both the target and the current position to zero.
- R7: After rst_n the registers hold these values: positions 0, slow and fast rate 0xFF, ramp rate and ramp amount 0x01, complement 0, wave_sel 0, power_down 0, interrupt bits 0, glitch count 0, ID pointer 0. Opcode 0110_1101 restores all of these except power_down, the glitch count and the ID pointer, which it leaves unchanged.
- R8: Opcode 1110_1111 returns {enable, pending} in bits 1:0. Opcode 1111_00ep sets enable to e and pending to p. Opcode 1111_010p sets only pending. Opcode 1111_011e sets only enable.
- R9: Opcode 0xFF increments the glitch count, which saturates at 0xFF. Opcode 0xFE returns the count and clears it to zero.
- R10: Opcode 0xFC returns ID byte i = 0x50 + 7*i and then advances i. After entry ID_LEN-1 the pointer wraps to 0 (ID_LEN defaults to 6). Opcode 0xFD sets the pointer to 0. Opcode 0xFB returns 0x00.
- R11: Every other opcode is taken in and has no effect. Examples are 0110_1110, 0111_xxxx, 10xx_xxxx, 1100_0000, 1110_1000 and 1111_1000. None of them produces a response or changes any register.
- R12: in_ready is high while the block is idle and while it is collecting operand bytes. It stays low from the acceptance of a read opcode, or of its last operand, until the last response byte has been accepted. While out_valid is high and out_ready is low, out_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound byte is present |
| in_ready | output | 1 | Block can take an inbound byte |
| in_data | input | 8 | Inbound opcode or operand byte |
| out_valid | output | 1 | Response byte is present |
| out_ready | input | 1 | Receiver takes the response byte |
| out_data | output | 8 | Response byte |
| pos_target | output | 16 | Target position |
| pos_current | output | 16 | Current position |
| rate_slow | output | 8 | Slow rate |
| rate_fast | output | 8 | Fast rate |
| ramp_rate | output | 8 | Ramp rate |
| ramp_amount | output | 8 | Ramp amount |
| comp_mask | output | 8 | Drive complement mask (bits 4 and 2:0 used) |
| wave_sel | output | 2 | Drive table selector |
| power_down | output | 1 | Power-down flag |
| irq_enable | output | 1 | Interrupt enable flag |
| irq_pending | output | 1 | Interrupt pending flag |

## Verification
The hand-off of the last response byte and the arrival of the next opcode can fall in the same cycle. The bench provokes this by driving a glitch-increment opcode with in_valid held high while a glitch-count response is still waiting. It then releases that byte with out_ready. The result is judged in three ways: the opcode must not be taken while in_ready is low, the returned byte must be the count from before the increment, and a later glitch read must show exactly one increment. A second overlap is a read and a write of the same state in one command (glitch read-and-clear). For this case the returned value must be the count from before the command.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
package cmdq_pkg;

    localparam int NREG = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPND = 2'd1,
        ST_RESP = 2'd2
    } cmdq_fsm_e;

    // 4-bit command nibble -> stored mask (nibble bit 3 lands on mask bit 4)
    function automatic logic [7:0] comp_from_nibble(input logic [3:0] nib);
        return {3'b000, nib[3], 1'b0, nib[2:0]};
    endfunction

    function automatic logic [7:0] comp_to_nibble(input logic [7:0] m);
        return {4'b0000, m[4], m[2:0]};
    endfunction

endpackage

// File: rtl/cmdq_opnd_count.sv
`timescale 1ns/1ps
module cmdq_opnd_count (
    input  logic [7:0] opcode,
    output logic [1:0] count
);
    always_comb begin
        if (opcode[7:3] == 5'b01000)
            count = 2'd1;
        else if (opcode[7:1] == 7'b0110100)
            count = 2'd2;
        else
            count = 2'd0;
    end
endmodule

// File: rtl/cmdq_id_rom.sv
`timescale 1ns/1ps
module cmdq_id_rom #(
    parameter int ID_LEN = 6,
    parameter int IDW    = 3
) (
    input  logic [IDW-1:0] idx,
    output logic [7:0]     data,
    output logic [IDW-1:0] idx_next
);
    localparam logic [IDW-1:0] LAST = IDW'(ID_LEN - 1);

    always_comb begin
        data     = 8'h50 + 8'(idx) * 8'd7;
        idx_next = (idx >= LAST) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/motor_cmd_decoder.sv
`timescale 1ns/1ps
module motor_cmd_decoder #(
    parameter int          ID_LEN     = 6,
    parameter logic [7:0]  SLOW_INIT  = 8'hFF,
    parameter logic [7:0]  FAST_INIT  = 8'hFF,
    parameter logic [7:0]  RRATE_INIT = 8'h01,
    parameter logic [7:0]  RAMT_INIT  = 8'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic [15:0] pos_target,
    output logic [15:0] pos_current,
    output logic [7:0]  rate_slow,
    output logic [7:0]  rate_fast,
    output logic [7:0]  ramp_rate,
    output logic [7:0]  ramp_amount,
    output logic [7:0]  comp_mask,
    output logic [1:0]  wave_sel,
    output logic        power_down,
    output logic        irq_enable,
    output logic        irq_pending
);
    import cmdq_pkg::*;

    localparam int IDW = (ID_LEN > 1) ? $clog2(ID_LEN) : 1;

    typedef struct packed {
        cmdq_fsm_e                fsm;
        logic [7:0]               cmd;
        logic [7:0]               opnd;
        logic [1:0]               need;
        logic [NREG-1:0][7:0]     rf;
        logic [7:0]               comp;
        logic [1:0]               wsel;
        logic                     pdn;
        logic                     ien;
        logic                     ipend;
        logic [7:0]               glitch;
        logic [IDW-1:0]           idp;
        logic [1:0][7:0]          resp;
        logic [1:0]               rcnt;
    } cmdq_state_t;

    cmdq_state_t st_q, st_d;

    logic [1:0]     new_need;
    logic [7:0]     id_byte;
    logic [IDW-1:0] id_next;
    logic           opnd_wait;

    cmdq_opnd_count u_cnt (.opcode(in_data), .count(new_need));

    cmdq_id_rom #(.ID_LEN(ID_LEN), .IDW(IDW)) u_id (
        .idx(st_q.idp), .data(id_byte), .idx_next(id_next)
    );

    // Values restored both by rst_n and (partly) by the reset opcode
    function automatic cmdq_state_t soft_init(input cmdq_state_t s);
        cmdq_state_t r;
        r       = s;
        r.rf    = '0;
        r.rf[4] = SLOW_INIT;
        r.rf[5] = FAST_INIT;
        r.rf[6] = RRATE_INIT;
        r.rf[7] = RAMT_INIT;
        r.comp  = '0;
        r.wsel  = '0;
        r.ien   = 1'b0;
        r.ipend = 1'b0;
        return r;
    endfunction

    assign opnd_wait = (st_q.fsm == ST_OPND);

    always_comb begin
        logic        acc, exec;
        logic [7:0]  op;
        logic [15:0] tgt;
        logic [1:0]  rn;
        logic [7:0]  r0, r1;

        st_d = st_q;
        acc  = in_valid && in_ready;
        op   = (st_q.fsm == ST_IDLE) ? in_data : st_q.cmd;
        tgt  = {st_q.rf[0], st_q.rf[1]};
        rn   = 2'd0;
        r0   = 8'h00;
        r1   = 8'h00;
        exec = 1'b0;

        // Drain response bytes
        if (st_q.fsm == ST_RESP && out_ready) begin
            if (st_q.rcnt == 2'd2) begin
                st_d.resp[0] = st_q.resp[1];
                st_d.rcnt    = 2'd1;
            end else begin
                st_d.rcnt = 2'd0;
                st_d.fsm  = ST_IDLE;
            end
        end

        if (acc && st_q.fsm == ST_IDLE && new_need != 2'd0) begin
            st_d.cmd  = in_data;
            st_d.need = new_need;
            st_d.fsm  = ST_OPND;
        end else if (acc && st_q.fsm == ST_OPND && st_q.need == 2'd2) begin
            st_d.opnd = in_data;
            st_d.need = 2'd1;
        end else if (acc) begin
            exec = 1'b1;
        end

        if (exec) begin
            casez (op)
                8'b000?????: {st_d.rf[0], st_d.rf[1]} = tgt + 16'd1;
                8'b001?????: {st_d.rf[0], st_d.rf[1]} = tgt - 16'd1;
                8'b01000???: st_d.rf[op[2:0]] = in_data;
                8'b01001???: begin r0 = st_q.rf[op[2:0]]; rn = 2'd1; end
                8'b0101????: st_d.comp = comp_from_nibble(op[3:0]);
                8'b011000??: st_d.wsel = op[1:0];
                8'b0110010?: st_d.pdn  = op[0];
                8'h66:       begin r0 = {7'b0, st_q.pdn};  rn = 2'd1; end
                8'h67:       begin r0 = {6'b0, st_q.wsel}; rn = 2'd1; end
                8'h68:       begin st_d.rf[0] = st_q.opnd; st_d.rf[1] = in_data; end
                8'h69:       begin st_d.rf[2] = st_q.opnd; st_d.rf[3] = in_data; end
                8'h6A:       begin r0 = st_q.rf[1]; r1 = st_q.rf[0]; rn = 2'd2; end
                8'h6B:       begin r0 = st_q.rf[3]; r1 = st_q.rf[2]; rn = 2'd2; end
                8'h6C:       begin r0 = comp_to_nibble(st_q.comp); rn = 2'd1; end
                8'h6D:       st_d = soft_init(st_d);
                8'h6F:       begin
                                 st_d.rf[0] = '0; st_d.rf[1] = '0;
                                 st_d.rf[2] = '0; st_d.rf[3] = '0;
                             end
                8'hEF:       begin r0 = {6'b0, st_q.ien, st_q.ipend}; rn = 2'd1; end
                8'b111100??: begin st_d.ien = op[1]; st_d.ipend = op[0]; end
                8'b1111010?: st_d.ipend = op[0];
                8'b1111011?: st_d.ien   = op[0];
                8'hFB:       rn = 2'd1;
                8'hFC:       begin r0 = id_byte; rn = 2'd1; st_d.idp = id_next; end
                8'hFD:       st_d.idp = '0;
                8'hFE:       begin r0 = st_q.glitch; rn = 2'd1; st_d.glitch = 8'h00; end
                8'hFF:       if (st_q.glitch != 8'hFF) st_d.glitch = st_q.glitch + 8'd1;
                default:     ;
            endcase
            st_d.need = 2'd0;
            st_d.resp = {r1, r0};
            st_d.rcnt = rn;
            st_d.fsm  = (rn != 2'd0) ? ST_RESP : ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= soft_init('0);
            st_q.fsm    <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready    = (st_q.fsm != ST_RESP);
    assign out_valid   = (st_q.fsm == ST_RESP);
    assign out_data    = st_q.resp[0];
    assign pos_target  = {st_q.rf[0], st_q.rf[1]};
    assign pos_current = {st_q.rf[2], st_q.rf[3]};
    assign rate_slow   = st_q.rf[4];
    assign rate_fast   = st_q.rf[5];
    assign ramp_rate   = st_q.rf[6];
    assign ramp_amount = st_q.rf[7];
    assign comp_mask   = st_q.comp;
    assign wave_sel    = st_q.wsel;
    assign power_down  = st_q.pdn;
    assign irq_enable  = st_q.ien;
    assign irq_pending = st_q.ipend;

endmodule

// File: rtl/cmdq_checker.sv
`timescale 1ns/1ps
module cmdq_checker #(
    parameter logic [7:0] SLOW_INIT = 8'hFF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [7:0]  in_data,
    input logic        out_valid,
    input logic        out_ready,
    input logic [7:0]  out_data,
    input logic        opnd_wait,
    input logic [15:0] pos_target,
    input logic [15:0] pos_current,
    input logic [7:0]  rate_slow
);
    logic new_cmd;
    assign new_cmd = in_valid && in_ready && !opnd_wait;

    p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (new_cmd && in_data[7:5] == 3'b000) |=> (pos_target == $past(pos_target) + 16'd1));

    p_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (new_cmd && in_data[7:5] == 3'b001) |=> (pos_target == $past(pos_target) - 16'd1));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (new_cmd && in_data == 8'h6F) |=> (pos_target == 16'd0 && pos_current == 16'd0));

    p_softrst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (new_cmd && in_data == 8'h6D) |=> (rate_slow == SLOW_INIT && pos_target == 16'd0));

    p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (new_cmd && in_data == 8'hC0) |=>
            (!out_valid && $stable(pos_target) && $stable(pos_current) && $stable(rate_slow)));
endmodule

bind motor_cmd_decoder cmdq_checker #(.SLOW_INIT(SLOW_INIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .opnd_wait(opnd_wait), .pos_target(pos_target),
    .pos_current(pos_current), .rate_slow(rate_slow)
);

// File: tb/sim_motor_cmd_decoder.sv
`timescale 1ns/1ps
module sim_motor_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic [15:0] pos_target, pos_current;
    logic [7:0]  rate_slow, rate_fast, ramp_rate, ramp_amount, comp_mask;
    logic [1:0]  wave_sel;
    logic        power_down, irq_enable, irq_pending;

    localparam int IDN = 6;

    int vectors = 0;
    int fails   = 0;

    // bench model
    logic [7:0] m_rf [8];
    logic [7:0] m_comp, m_gl;
    logic [1:0] m_wsel;
    logic       m_pdn, m_ien, m_ipd;
    int         m_idp;

    always #10 clk = ~clk;

    motor_cmd_decoder #(.ID_LEN(IDN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .pos_target(pos_target), .pos_current(pos_current),
        .rate_slow(rate_slow), .rate_fast(rate_fast), .ramp_rate(ramp_rate),
        .ramp_amount(ramp_amount), .comp_mask(comp_mask), .wave_sel(wave_sel),
        .power_down(power_down), .irq_enable(irq_enable), .irq_pending(irq_pending)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_soft();
        for (int i = 0; i < 4; i++) m_rf[i] = 8'h00;
        m_rf[4] = 8'hFF; m_rf[5] = 8'hFF; m_rf[6] = 8'h01; m_rf[7] = 8'h01;
        m_comp = 8'h00; m_wsel = 2'd0; m_ien = 1'b0; m_ipd = 1'b0;
    endtask

    function automatic int n_operands(input logic [7:0] c);
        if (c >= 8'h40 && c <= 8'h47) return 1;
        if (c == 8'h68 || c == 8'h69) return 2;
        return 0;
    endfunction

    // Expected effect of one command per the requirements
    task automatic model(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b,
                         output int n, output logic [7:0] e0, output logic [7:0] e1);
        logic [15:0] t;
        n = 0; e0 = 8'h00; e1 = 8'h00;
        t = {m_rf[0], m_rf[1]};
        if (c < 8'h20) begin t = t + 16'd1; m_rf[0] = t[15:8]; m_rf[1] = t[7:0]; end
        else if (c < 8'h40) begin t = t - 16'd1; m_rf[0] = t[15:8]; m_rf[1] = t[7:0]; end
        else if (c < 8'h48) m_rf[c[2:0]] = a;
        else if (c < 8'h50) begin n = 1; e0 = m_rf[c[2:0]]; end
        else if (c < 8'h60) m_comp = {3'b0, c[3], 1'b0, c[2:0]};
        else if (c < 8'h64) m_wsel = c[1:0];
        else if (c < 8'h66) m_pdn = c[0];
        else if (c == 8'h66) begin n = 1; e0 = m_pdn ? 8'h01 : 8'h00; end
        else if (c == 8'h67) begin n = 1; e0 = {6'b0, m_wsel}; end
        else if (c == 8'h68) begin m_rf[0] = a; m_rf[1] = b; end
        else if (c == 8'h69) begin m_rf[2] = a; m_rf[3] = b; end
        else if (c == 8'h6A) begin n = 2; e0 = m_rf[1]; e1 = m_rf[0]; end
        else if (c == 8'h6B) begin n = 2; e0 = m_rf[3]; e1 = m_rf[2]; end
        else if (c == 8'h6C) begin n = 1; e0 = {4'b0, m_comp[4], m_comp[2:0]}; end
        else if (c == 8'h6D) model_soft();
        else if (c == 8'h6F) begin for (int i = 0; i < 4; i++) m_rf[i] = 8'h00; end
        else if (c == 8'hEF) begin n = 1; e0 = {6'b0, m_ien, m_ipd}; end
        else if (c >= 8'hF0 && c <= 8'hF3) begin m_ien = c[1]; m_ipd = c[0]; end
        else if (c == 8'hF4 || c == 8'hF5) m_ipd = c[0];
        else if (c == 8'hF6 || c == 8'hF7) m_ien = c[0];
        else if (c == 8'hFB) n = 1;
        else if (c == 8'hFC) begin
            n = 1; e0 = 8'h50 + 8'(7 * m_idp);
            m_idp = (m_idp == IDN - 1) ? 0 : m_idp + 1;
        end
        else if (c == 8'hFD) m_idp = 0;
        else if (c == 8'hFE) begin n = 1; e0 = m_gl; m_gl = 8'h00; end
        else if (c == 8'hFF) begin if (m_gl != 8'hFF) m_gl = m_gl + 8'd1; end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_data = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic get(output logic [7:0] b, input int stall);
        logic [7:0] first;
        out_ready = 1'b0;
        while (!out_valid) @(negedge clk);
        first = out_data;
        for (int i = 0; i < stall; i++) begin
            chk("R12 in_ready low while reply waits", in_ready, 1'b0);
            @(negedge clk);
            chk("R12 out_data held", out_data, first);
        end
        b = out_data;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic check_ports(input logic [7:0] c);
        chk($sformatf("R2 target after %0h", c), pos_target, {m_rf[0], m_rf[1]});
        chk($sformatf("R5 current after %0h", c), pos_current, {m_rf[2], m_rf[3]});
        chk("R2 rates", {rate_slow, rate_fast, ramp_rate, ramp_amount},
            {m_rf[4], m_rf[5], m_rf[6], m_rf[7]});
        chk("R3 comp_mask", comp_mask, m_comp);
        chk("R4 wave/pdn", {wave_sel, power_down}, {m_wsel, m_pdn});
        chk("R8 irq bits", {irq_enable, irq_pending}, {m_ien, m_ipd});
    endtask

    task automatic run_cmd(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b);
        int n, k;
        logic [7:0] e0, e1, v;
        k = n_operands(c);
        put(c);
        if (k >= 1) put(a);
        if (k == 2) put(b);
        model(c, a, b, n, e0, e1);
        if (n >= 1) begin
            get(v, int'($urandom_range(0, 2)));
            chk($sformatf("R2 reply0 of %0h", c), v, e0);
        end
        if (n == 2) begin
            get(v, 0);
            chk($sformatf("R5 reply1 of %0h", c), v, e1);
        end
        if (n == 0) begin
            @(negedge clk);
            chk($sformatf("R11 no reply for %0h", c), out_valid, 1'b0);
        end
        chk("R12 ready when idle", in_ready, 1'b1);
        check_ports(c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        model_soft();
        m_pdn = 1'b0; m_gl = 8'h00; m_idp = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset handshake", {in_ready, out_valid}, 2'b10);
        check_ports(8'h00);

        // R1 wrap both ways
        run_cmd(8'h68, 8'hFF, 8'hFF);
        run_cmd(8'h05, 8'h00, 8'h00);
        chk("R1 inc wraps to 0", pos_target, 16'h0000);
        run_cmd(8'h3A, 8'h00, 8'h00);
        chk("R1 dec wraps to FFFF", pos_target, 16'hFFFF);
        run_cmd(8'h41, 8'hFF, 8'h00);
        run_cmd(8'h1F, 8'h00, 8'h00);
        chk("R1 carry to high byte", pos_target, 16'h0000);

        // R5 two-byte loads and reads, R6 clear
        run_cmd(8'h69, 8'h12, 8'h34);
        run_cmd(8'h6B, 8'h00, 8'h00);
        run_cmd(8'h6A, 8'h00, 8'h00);
        run_cmd(8'h6F, 8'h00, 8'h00);

        // R3 remap
        run_cmd(8'h5A, 8'h00, 8'h00);
        chk("R3 comp 5A", comp_mask, 8'h12);
        run_cmd(8'h6C, 8'h00, 8'h00);

        // R4, R8, R7 soft reset keeps power-down
        run_cmd(8'h65, 8'h00, 8'h00);
        run_cmd(8'h62, 8'h00, 8'h00);
        run_cmd(8'hF3, 8'h00, 8'h00);
        run_cmd(8'hF4, 8'h00, 8'h00);
        run_cmd(8'hEF, 8'h00, 8'h00);
        run_cmd(8'h44, 8'h33, 8'h00);
        run_cmd(8'h6D, 8'h00, 8'h00);
        chk("R7 power_down kept", power_down, 1'b1);

        // R9 saturation
        for (int i = 0; i < 260; i++) run_cmd(8'hFF, 8'h00, 8'h00);
        run_cmd(8'hFE, 8'h00, 8'h00);
        run_cmd(8'hFE, 8'h00, 8'h00);

        // R12/R9: next opcode waiting while the reply drains
        run_cmd(8'hFF, 8'h00, 8'h00);
        put(8'hFE);
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'hFF;
        chk("R12 opcode held off", in_ready, 1'b0);
        chk("R9 read before increment", out_data, 8'h01);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R12 ready after last reply", in_ready, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        m_gl = 8'h01;
        run_cmd(8'hFE, 8'h00, 8'h00);

        // R10 ID wrap and pointer reset
        for (int i = 0; i < 8; i++) run_cmd(8'hFC, 8'h00, 8'h00);
        run_cmd(8'hFD, 8'h00, 8'h00);
        run_cmd(8'hFC, 8'h00, 8'h00);
        run_cmd(8'hFB, 8'h00, 8'h00);

        // R11 unassigned
        run_cmd(8'hC0, 8'h00, 8'h00);
        run_cmd(8'h6E, 8'h00, 8'h00);
        run_cmd(8'hF8, 8'h00, 8'h00);
        run_cmd(8'h93, 8'h00, 8'h00);

        // random mix
        for (int i = 0; i < 700; i++) begin
            v = 8'($urandom_range(0, 255));
            run_cmd(v, 8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule